// File: doc/BRIEF.md
# Interrupt Flag Register with Pin Routing

This block keeps a 16-bit word of sticky interrupt flags for a radio modem. Ten of the bits stand for defined modem events; the upper six never hold a value. Single-cycle event pulses arriving from the modem side set their flag when the matching bit of a global enable mask is on. The flags then stay set until the host clears them with a 16-bit clear word.

Three interrupt output pins are derived from the flags. Each pin has its own routing mask. A pin is raised when some flag is set whose bit is on in both the global mask and that pin's mask. All four masks are loaded together as one 64-bit configuration word.

Two of the pins can be given other duties. When pin 2 acts as the antenna-switch control, it follows the transmit-active signal. When pin 3 acts as the oscillator supply control, it carries no interrupt at all. The pin outputs are registered.

Top module: `evt_flag_router`

## Requirements
- R1: After reset the status word is 0x0000, all three pins are low and all four masks are zero.
- R2: Event bits are: 0 transmit done, 1 receive done, 2 preamble seen, 3 sync word valid, 4 header valid, 5 header error, 6 CRC error, 7 activity scan finished, 8 activity found, 9 timeout. A pulse on an event bit whose global-mask bit is 1 sets that status bit, and the change is visible one cycle after the pulse.
- R3: A pulse on an event bit whose global-mask bit is 0 leaves the status word unchanged.
- R4: A set flag stays set while no clear names it.
- R5: When `clr_en` is high, each 1 in `clr_mask` clears the matching flag, and each 0 leaves its flag unchanged.
- R6: When an event pulse and a clear hit the same bit in the same cycle, the flag ends up set.
- R7: Status bits 10 to 15 always read 0, and they never raise a pin, whatever the masks or the pulses.
- R8: A cycle with `cfg_wr` high loads `cfg_masks`, which is laid out as follows: global mask in [63:48], pin 1 mask in [47:32], pin 2 mask in [31:16], pin 3 mask in [15:0]. A change of the global mask does not alter flags that are already set.
- R9: In interrupt duty, `irq_pin[k]` (bit 0 is pin 1) is high exactly when some flag is set whose bit is also on in the global mask and in that pin's mask. The pin shows the flags and masks as they were one cycle earlier.
- R10: While `rfsw_mode` is high, `irq_pin[1]` equals `tx_active` as it was one cycle earlier and carries no interrupt.
- R11: While `osc_mode` is high, `irq_pin[2]` is low, even when an interrupt is routed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 16 | Event pulses, one bit per event |
| cfg_wr | input | 1 | Load strobe for the four masks |
| cfg_masks | input | 64 | Global, pin 1, pin 2 and pin 3 masks, most significant first |
| clr_en | input | 1 | Clear command strobe |
| clr_mask | input | 16 | Flags to clear, one bit per flag |
| rfsw_mode | input | 1 | Pin 2 drives the antenna switch |
| osc_mode | input | 1 | Pin 3 drives the oscillator supply |
| tx_active | input | 1 | Transmitter is active |
| irq_pin | output | 3 | Pins 1 to 3 |
| status | output | 16 | Flag word |

## Verification
The hardest case to reach is a single cycle in which an event pulse and a clear name the same bit while other bits are cleared alongside it. If the order of set and clear were wrong, only that one bit would come out differently. The stimulus table puts a combined pulse and clear into one row, and a pulse on two bits together with a full clear into the next row. Because the pins are registered, the mode-takeover checks first build up a routed, pending interrupt. Only then do they switch each alternate duty on and off, so that a suppressed pin is told apart from a pin that simply has no flag to show.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int FLAG_W = 16;
  localparam logic [FLAG_W-1:0] DEFINED_BITS = 16'h03FF;

  typedef logic [FLAG_W-1:0] flag_word_t;

  // set wins over clear; only defined, globally enabled events latch
  function automatic flag_word_t flags_next(input flag_word_t cur,
                                            input flag_word_t evt,
                                            input flag_word_t gmask,
                                            input logic       clr_en,
                                            input flag_word_t clr,
                                            input flag_word_t defined);
    flag_word_t kept;
    kept = clr_en ? (cur & ~clr) : cur;
    return (kept | (evt & gmask)) & defined;
  endfunction

  function automatic logic route_hit(input flag_word_t flags,
                                     input flag_word_t gmask,
                                     input flag_word_t pmask,
                                     input flag_word_t defined);
    return |(flags & gmask & pmask & defined);
  endfunction
endpackage

// File: rtl/irqr_flag_bank.sv
module irqr_flag_bank
  import irqr_pkg::*;
#(
  parameter int W = FLAG_W,
  parameter logic [W-1:0] DEF_MASK = DEFINED_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] gmask,
  input  logic         clr_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags
);
  logic [W-1:0] evt_accepted;
  logic [W-1:0] flags_d;

  assign evt_accepted = evt & gmask & DEF_MASK;
  assign flags_d      = flags_next(flags, evt, gmask, clr_en, clr, DEF_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(evt_accepted)) == $past(evt_accepted)));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((flags & $past(flags)) == $past(flags)));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((flags & $past(clr & ~evt_accepted)) == '0));

  a_r3_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && ((evt & ~gmask) != '0)) |=> ((flags & ~$past(flags) & $past(~gmask)) == '0));

  a_r7_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~DEF_MASK) == '0);
endmodule

// File: rtl/irqr_mask_regs.sv
module irqr_mask_regs #(
  parameter int W    = 16,
  parameter int NPIN = 3,
  localparam int CFG_W = (NPIN + 1) * W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [CFG_W-1:0]         data,
  output logic [W-1:0]             gmask,
  output logic [NPIN-1:0][W-1:0]   pmask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  gmask <= '0;
    else if (wr) gmask <= data[CFG_W-1 -: W];
  end

  for (genvar k = 0; k < NPIN; k++) begin : g_pin_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pmask[k] <= '0;
      else if (wr) pmask[k] <= data[(NPIN-k)*W-1 -: W];
    end
  end

  a_r8_global_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (gmask == $past(data[CFG_W-1 -: W])));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(gmask));
endmodule

// File: rtl/irqr_pin_drive.sv
module irqr_pin_drive
  import irqr_pkg::*;
#(
  parameter int W    = FLAG_W,
  parameter int NPIN = 3,
  parameter logic [W-1:0] DEF_MASK = DEFINED_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           flags,
  input  logic [W-1:0]           gmask,
  input  logic [NPIN-1:0][W-1:0] pmask,
  input  logic                   rfsw_mode,
  input  logic                   osc_mode,
  input  logic                   tx_active,
  output logic [NPIN-1:0]        pins
);
  logic [NPIN-1:0] hit;

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    assign hit[k] = route_hit(flags, gmask, pmask[k], DEF_MASK);

    if (k == 1) begin : g_rfsw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pins[k] <= 1'b0;
        else if (rfsw_mode) pins[k] <= tx_active;
        else                pins[k] <= hit[k];
      end
      a_r10_rfsw: assert property (@(posedge clk) disable iff (!rst_n)
        rfsw_mode |=> (pins[k] == $past(tx_active)));
    end else if (k == 2) begin : g_osc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pins[k] <= 1'b0;
        else if (osc_mode) pins[k] <= 1'b0;
        else               pins[k] <= hit[k];
      end
      a_r11_osc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        osc_mode |=> !pins[k]);
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins[k] <= 1'b0;
        else        pins[k] <= hit[k];
      end
      a_r9_no_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |=> !pins[k]);
    end
  end
endmodule

// File: rtl/evt_flag_router.sv
module evt_flag_router
  import irqr_pkg::*;
#(
  parameter int W    = FLAG_W,
  parameter int NPIN = 3,
  parameter logic [W-1:0] DEF_MASK = DEFINED_BITS,
  localparam int CFG_W = (NPIN + 1) * W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     evt_pulse,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_masks,
  input  logic             clr_en,
  input  logic [W-1:0]     clr_mask,
  input  logic             rfsw_mode,
  input  logic             osc_mode,
  input  logic             tx_active,
  output logic [NPIN-1:0]  irq_pin,
  output logic [W-1:0]     status
);
  logic [W-1:0]           gmask;
  logic [NPIN-1:0][W-1:0] pmask;
  logic [W-1:0]           flags;

  irqr_mask_regs #(.W(W), .NPIN(NPIN)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .data(cfg_masks),
    .gmask(gmask), .pmask(pmask)
  );

  irqr_flag_bank #(.W(W), .DEF_MASK(DEF_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .gmask(gmask),
    .clr_en(clr_en), .clr(clr_mask), .flags(flags)
  );

  irqr_pin_drive #(.W(W), .NPIN(NPIN), .DEF_MASK(DEF_MASK)) u_pins (
    .clk(clk), .rst_n(rst_n), .flags(flags), .gmask(gmask), .pmask(pmask),
    .rfsw_mode(rfsw_mode), .osc_mode(osc_mode), .tx_active(tx_active),
    .pins(irq_pin)
  );

  assign status = flags;

  a_r1_reset_pins: assert property (@(posedge clk)
    !rst_n |-> (irq_pin == '0 && status == '0));
endmodule

// File: tb/evt_flag_router_tb.sv
module evt_flag_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_pulse = '0;
  logic        cfg_wr = 1'b0;
  logic [63:0] cfg_masks = '0;
  logic        clr_en = 1'b0;
  logic [15:0] clr_mask = '0;
  logic        rfsw_mode = 1'b0;
  logic        osc_mode = 1'b0;
  logic        tx_active = 1'b0;
  logic [2:0]  irq_pin;
  logic [15:0] status;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  evt_flag_router u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cfg_wr(cfg_wr),
    .cfg_masks(cfg_masks), .clr_en(clr_en), .clr_mask(clr_mask),
    .rfsw_mode(rfsw_mode), .osc_mode(osc_mode), .tx_active(tx_active),
    .irq_pin(irq_pin), .status(status)
  );

  typedef struct packed {
    logic [15:0] evt;
    logic        clr_on;
    logic [15:0] clr;
    logic [15:0] exp;
  } vec_t;

  // global mask during table: 0xFEFF (bit 8 disabled)
  localparam vec_t VECS [10] = '{
    '{16'h0001, 1'b0, 16'h0000, 16'h0001},  // R2 tx done
    '{16'h0100, 1'b0, 16'h0000, 16'h0001},  // R3 masked event
    '{16'h0200, 1'b0, 16'h0000, 16'h0201},  // R2 timeout
    '{16'hF000, 1'b0, 16'h0000, 16'h0201},  // R7 undefined bits
    '{16'h0000, 1'b0, 16'h0000, 16'h0201},  // R4 sticky
    '{16'h0000, 1'b1, 16'h0001, 16'h0200},  // R5 partial clear
    '{16'h0040, 1'b1, 16'h0040, 16'h0240},  // R6 set beats clear
    '{16'h0082, 1'b1, 16'hFFFF, 16'h0082},  // R6 with full clear
    '{16'h0000, 1'b1, 16'h0002, 16'h0080},  // R5 single bit
    '{16'h003C, 1'b0, 16'h0000, 16'h00BC}   // R2 several at once
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic load_masks(input logic [15:0] g, input logic [15:0] p1,
                            input logic [15:0] p2, input logic [15:0] p3);
    cfg_masks = {g, p1, p2, p3};
    cfg_wr = 1'b1;
    step();
    cfg_wr = 1'b0;
  endtask

  initial begin
    #20;
    chk("R1 status in reset", {16'h0, status}, 32'h0);
    chk("R1 pins in reset", {29'h0, irq_pin}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    evt_pulse = 16'h03FF;
    step();
    evt_pulse = '0;
    chk("R1 masks zero block events", {16'h0, status}, 32'h0);

    load_masks(16'hFEFF, 16'h0, 16'h0, 16'h0);
    for (int i = 0; i < 10; i++) begin
      evt_pulse = VECS[i].evt;
      clr_en    = VECS[i].clr_on;
      clr_mask  = VECS[i].clr;
      step();
      chk($sformatf("R2-R7 table row %0d", i), {16'h0, status}, {16'h0, VECS[i].exp});
    end
    evt_pulse = '0; clr_en = 1'b0; clr_mask = '0;

    // status = 0x00BC; route bit 7 to pin 1, bit 2 to pin 2, bit 8 to pin 3
    load_masks(16'hFFFF, 16'h0080, 16'h0004, 16'h0100);
    chk("R9 pins lag mask load", {29'h0, irq_pin}, 32'h0);
    step();
    chk("R9 routed pins", {29'h0, irq_pin}, 32'h3);

    load_masks(16'hFF7B, 16'h0080, 16'h0004, 16'h0100);
    chk("R8 global mask keeps flags", {16'h0, status}, 32'h00BC);
    step();
    chk("R9 global mask gates pins", {29'h0, irq_pin}, 32'h0);

    load_masks(16'hFFFF, 16'hFC00, 16'h0004, 16'h0100);
    evt_pulse = 16'h0100;
    step();
    evt_pulse = '0;
    chk("R2 activity found latched", {16'h0, status}, 32'h01BC);
    chk("R9 pin 3 not yet", {31'h0, irq_pin[2]}, 32'h0);
    step();
    chk("R9 pin 3 raised", {31'h0, irq_pin[2]}, 32'h1);
    chk("R7 upper-bit mask never raises pin 1", {31'h0, irq_pin[0]}, 32'h0);

    osc_mode = 1'b1;
    step();
    chk("R11 pin 3 suppressed", {31'h0, irq_pin[2]}, 32'h0);
    step();
    chk("R11 pin 3 stays low", {31'h0, irq_pin[2]}, 32'h0);
    osc_mode = 1'b0;
    step();
    chk("R11 pin 3 back to interrupt", {31'h0, irq_pin[2]}, 32'h1);

    rfsw_mode = 1'b1; tx_active = 1'b0;
    step();
    chk("R10 pin 2 low outside transmit", {31'h0, irq_pin[1]}, 32'h0);
    tx_active = 1'b1;
    step();
    chk("R10 pin 2 high in transmit", {31'h0, irq_pin[1]}, 32'h1);
    tx_active = 1'b0;
    step();
    chk("R10 pin 2 follows transmit end", {31'h0, irq_pin[1]}, 32'h0);
    rfsw_mode = 1'b0;
    step();
    chk("R10 pin 2 back to interrupt", {31'h0, irq_pin[1]}, 32'h1);

    clr_en = 1'b1; clr_mask = 16'hFFFF;
    step();
    clr_en = 1'b0; clr_mask = '0;
    chk("R5 full clear", {16'h0, status}, 32'h0);
    step();
    chk("R9 pins drop after clear", {29'h0, irq_pin}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule